// File: doc/BRIEF.md
# Start-of-Frame Watchdog with Host-Loss Detection

This block watches the periodic start-of-frame (SOF) strobes that a host sends to a full-speed serial bus device while the link is up. A timer, advanced by a one-microsecond tick, measures the time since the last SOF. When it reaches a programmable timeout the block raises a one-cycle miss pulse. The timer then starts over at once, so a silent host produces a steady train of miss pulses, one per timeout period.

Consecutive misses are counted. Once a set number of misses has accumulated with no SOF between them, the block declares the host lost and holds that level. The level clears only when an SOF arrives, when the link drops or when a bus reset is signalled. The surrounding device logic uses the miss pulse to keep its frame count running and uses the host-lost level to decide whether to fall back to an idle or suspended state.

Top module: `sof_watchdog`

## Requirements
- R1: After reset the miss pulse and the host-lost level are both 0, and the timer and the miss count start from zero.
- R2: The timer advances by one only in a cycle with `usTick` high. When no tick arrives, no miss pulse is produced, however long the wait.
- R3: `sofMissed` is high in exactly the cycle in which the timer equals `TIMEOUT_US`. With the timer started from zero, that is the cycle after the `TIMEOUT_US`-th tick edge. The pulse lasts one cycle.
- R4: In the cycle after a miss pulse the timer is zero again, so the next miss needs another `TIMEOUT_US` ticks.
- R5: An SOF strobe (`sofSeen` high) zeroes the timer and the miss count, and it clears host-lost at the next edge.
- R6: While `linkUp` is low the timer and the miss count are held at zero. No miss pulse occurs and host-lost is 0 from the next cycle on.
- R7: A link-reset strobe (`linkRst` high) zeroes the timer and the miss count at the next edge.
- R8: `hostLost` rises in the cycle after the `MISS_LIMIT`-th consecutive miss pulse.
- R9: Host-lost saturates. The count never passes `MISS_LIMIT`, and further miss pulses keep `hostLost` high until an SOF, a link drop or a link reset occurs.
- R10: When an SOF and a miss pulse fall in the same cycle, the pulse is still shown in that cycle, but the SOF wins for the count: the miss is not counted and the count becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sofSeen | input | 1 | SOF received this cycle |
| linkUp | input | 1 | Link is in an active state |
| linkRst | input | 1 | Bus reset detected this cycle |
| usTick | input | 1 | One-microsecond tick strobe |
| sofMissed | output | 1 | One-cycle pulse at timeout |
| hostLost | output | 1 | Host declared lost, held level |

## Verification
The two functions that collide are the miss pulse and the clearing by an SOF. Both act on the timer and on the miss count at the same edge. The bench runs a silent link up to the timeout and then drives `sofSeen` in exactly the cycle whose timer value equals the timeout. It checks that the pulse is visible in that cycle and that, after the edge, the count behaves as if the miss had never happened: host-lost stays low and a full timeout period passes before the next pulse. The same collision also occurs in a long stretch of pseudo-random SOF, tick, reset and link-drop stimulus, and there every cycle is compared with an arithmetic model.

// File: rtl/sof_watchdog_pkg.sv
package sof_watchdog_pkg;

  // Strobes from control to datapath, one decision per cycle.
  typedef struct packed {
    logic timerClr;  // restart timer at zero
    logic timerInc;  // advance timer by one
    logic missClr;   // zero the miss count
    logic missInc;   // count one more miss
  } monStrobe_t;

endpackage

// File: rtl/sof_watchdog_ctrl.sv
module sof_watchdog_ctrl
  import sof_watchdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sofSeen,
  input  logic       linkUp,
  input  logic       linkRst,
  input  logic       usTick,
  input  logic       atTimeout,
  input  logic       atLimit,
  output monStrobe_t strobe
);

  logic quiesce;

  always_comb begin
    quiesce         = sofSeen | ~linkUp | linkRst;
    strobe.timerClr = quiesce | atTimeout;
    strobe.timerInc = ~(quiesce | atTimeout) & usTick;
    strobe.missClr  = quiesce;
    strobe.missInc  = ~quiesce & atTimeout & ~atLimit;
  end

  // R9: once saturated, no further count request is issued
  a_r9_no_inc_when_lost: assert property (@(posedge clk) disable iff (!rstN)
    atLimit |-> !strobe.missInc);

  // R10: a clearing cause always beats a miss for the count
  a_r10_clear_beats_miss: assert property (@(posedge clk) disable iff (!rstN)
    strobe.missClr |-> !strobe.missInc);

endmodule

// File: rtl/sof_watchdog_dp.sv
module sof_watchdog_dp
  import sof_watchdog_pkg::*;
#(
  parameter int unsigned TIMEOUT_US = 1024,
  parameter int unsigned MISS_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  monStrobe_t strobe,
  output logic       atTimeout,
  output logic       atLimit
);

  localparam int unsigned TW = $clog2(TIMEOUT_US + 1);
  localparam int unsigned CW = $clog2(MISS_LIMIT + 1);
  localparam logic [TW-1:0] TMAX = TW'(TIMEOUT_US);
  localparam logic [CW-1:0] CMAX = CW'(MISS_LIMIT);

  logic [TW-1:0] timer;
  logic [CW-1:0] missCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.timerClr) begin
      timer <= '0;
    end else if (strobe.timerInc) begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missCnt <= '0;
    end else if (strobe.missClr) begin
      missCnt <= '0;
    end else if (strobe.missInc) begin
      missCnt <= missCnt + 1'b1;
    end
  end

  assign atTimeout = (timer == TMAX);
  assign atLimit   = (missCnt == CMAX);

  // R2: without a tick or a clear the timer does not move
  a_r2_timer_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.timerClr && !strobe.timerInc) |=> $stable(timer));

  // R4: a timeout always restarts the timer from zero
  a_r4_restart: assert property (@(posedge clk) disable iff (!rstN)
    atTimeout |=> (timer == '0));

  // R9: count never passes its limit
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    missCnt <= CMAX);

  // R2: timer never passes the timeout
  a_r2_timer_bounded: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TMAX);

endmodule

// File: rtl/sof_watchdog.sv
module sof_watchdog
  import sof_watchdog_pkg::*;
#(
  parameter int unsigned TIMEOUT_US = 1024,
  parameter int unsigned MISS_LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sofSeen,
  input  logic linkUp,
  input  logic linkRst,
  input  logic usTick,
  output logic sofMissed,
  output logic hostLost
);

  monStrobe_t strobe;
  logic       atTimeout;
  logic       atLimit;

  sof_watchdog_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sofSeen   (sofSeen),
    .linkUp    (linkUp),
    .linkRst   (linkRst),
    .usTick    (usTick),
    .atTimeout (atTimeout),
    .atLimit   (atLimit),
    .strobe    (strobe)
  );

  sof_watchdog_dp #(
    .TIMEOUT_US (TIMEOUT_US),
    .MISS_LIMIT (MISS_LIMIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .atTimeout (atTimeout),
    .atLimit   (atLimit)
  );

  assign sofMissed = atTimeout;
  assign hostLost  = atLimit;

  // R3: miss pulse is one cycle wide
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sofMissed |=> !sofMissed);

  // R5: SOF clears host-lost
  a_r5_sof_clears: assert property (@(posedge clk) disable iff (!rstN)
    sofSeen |=> !hostLost);

  // R6: inactive link gives quiet outputs next cycle
  a_r6_inactive_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |=> (!sofMissed && !hostLost));

  // R7: link reset clears both outputs next cycle
  a_r7_rst_clears: assert property (@(posedge clk) disable iff (!rstN)
    linkRst |=> (!sofMissed && !hostLost));

  // R8: host-lost only rises right after a miss pulse
  a_r8_rise_after_miss: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostLost) |-> $past(sofMissed));

  // R9: host-lost holds while nothing clears it
  a_r9_lost_holds: assert property (@(posedge clk) disable iff (!rstN)
    (hostLost && linkUp && !sofSeen && !linkRst) |=> hostLost);

endmodule

// File: tb/sof_watchdog_bench.sv
module sof_watchdog_bench;

  localparam int T = 5;
  localparam int L = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sofSeen = 1'b0, linkUp = 1'b0, linkRst = 1'b0, usTick = 1'b0;
  logic sofMissed, hostLost;

  int nChecks = 0;
  int nFails  = 0;
  int expT = 0;
  int expC = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  sof_watchdog #(.TIMEOUT_US(T), .MISS_LIMIT(L)) u_sof_watchdog (
    .clk(clk), .rstN(rstN), .sofSeen(sofSeen), .linkUp(linkUp),
    .linkRst(linkRst), .usTick(usTick), .sofMissed(sofMissed), .hostLost(hostLost)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0b expected %0b at time %0t", tag, got, exp, $time);
    end
  endtask

  // One clock: drive at negedge, update arithmetic model, compare at next negedge.
  task automatic step(input logic s, input logic up, input logic r, input logic tk,
                      input string tagP, input string tagL);
    bit clr;
    sofSeen = s; linkUp = up; linkRst = r; usTick = tk;
    @(posedge clk);
    clr = s || !up || r;
    if (clr) expC = 0;
    else if (expT == T && expC != L) expC++;
    if (clr || expT == T) expT = 0;
    else if (tk) expT++;
    @(negedge clk);
    chk(sofMissed, expT == T, tagP);
    chk(hostLost, expC == L, tagL);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nFails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sofMissed, 1'b0, "R1");
    chk(hostLost, 1'b0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    chk(sofMissed, 1'b0, "R1");
    chk(hostLost, 1'b0, "R1");

    // R3/R4/R8: silent host, tick every cycle, past saturation (R9)
    for (int i = 0; i < (T + 1) * (L + 3); i++) step(0, 1, 0, 1, "R4", "R8");
    chk(hostLost, 1'b1, "R9");

    // R5: SOF clears
    step(1, 1, 0, 1, "R5", "R5");
    chk(hostLost, 1'b0, "R5");

    // R2: no ticks, long wait, no pulse
    for (int i = 0; i < 60; i++) step(0, 1, 0, 0, "R2", "R2");
    chk(sofMissed, 1'b0, "R2");

    // R2/R3: sweep tick spacing
    for (int p = 1; p <= 4; p++) begin
      step(1, 1, 0, 0, "R5", "R5");
      for (int i = 0; i < p * (T + 1) * (L + 1); i++)
        step(0, 1, 0, (i % p) == 0, "R3", "R8");
    end

    // R6: link down with ticks
    for (int i = 0; i < 3 * T; i++) step(0, 0, 0, 1, "R6", "R6");
    chk(hostLost, 1'b0, "R6");

    // R7: reach host-lost then link reset
    for (int i = 0; i < (T + 1) * L + 2; i++) step(0, 1, 0, 1, "R3", "R8");
    chk(hostLost, 1'b1, "R8");
    step(0, 1, 1, 1, "R7", "R7");
    chk(hostLost, 1'b0, "R7");

    // R10: SOF in the pulse cycle
    for (int i = 0; i < T; i++) step(0, 1, 0, 1, "R3", "R10");
    chk(sofMissed, 1'b1, "R10");
    step(1, 1, 0, 1, "R10", "R10");
    for (int i = 0; i < T - 1; i++) step(0, 1, 0, 1, "R10", "R10");
    chk(sofMissed, 1'b0, "R10");

    // Pseudo-random mix
    for (int i = 0; i < 4000; i++)
      step(($urandom % 23) == 0, ($urandom % 61) != 0, ($urandom % 97) == 0,
           ($urandom % 3) != 0, "R10", "R9");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule